// File: doc/BRIEF.md
# Dual-View Static Memory

This block models a static memory that a host can address either as 16-bit words or as 8-bit bytes. A mode input picks the view. In word view the block takes a word address, a 16-bit data bus and two active-low byte-lane enables. In byte view, data line 15 is taken as the least significant address bit, and data moves only on lines 0 to 7. Both views address the same storage. Byte address 2n selects bits 7:0 of word n, and byte address 2n+1 selects bits 15:8 of word n.

All pins are sampled on the rising edge of a system clock. Two chip selects gate every access: one is active low and one is active high. The remaining controls decode into standby, read, write or output-disable. Tri-state pins are replaced by a unidirectional read bus plus three output-enable flags: one for lines 0-7, one for lines 8-14 and one for line 15. A host or bench can therefore see exactly which lanes a real part would drive. The depth in words is a parameter.

Top module: `dual_view_sram`

## Requirements
- R1: When `sel_n` is high or `sel` is low, the access is standby. All three lane flags are low, `rd_data` is zero and no storage changes.
- R2: In word view (`word_mode`=1) with `lo_en_n` and `hi_en_n` both high, the access is standby and no storage changes.
- R3: A word-view write with `wr_n`=0 stores `wr_data[7:0]` into bits 7:0 of word `addr` when `lo_en_n`=0. It stores `wr_data[15:8]` into bits 15:8 when `hi_en_n`=0. A lane whose enable is high keeps its contents.
- R4: A write is chosen by `wr_n`=0 whatever the value of `rd_n`. During a write all lane flags are low and `rd_data` is zero.
- R5: A word-view read (`wr_n`=1, `rd_n`=0) with `lo_en_n`=0 raises `drv_lo` and returns bits 7:0 of word `addr` on `rd_data[7:0]`. With `hi_en_n`=0 it raises `drv_mid` and `drv_top` and returns bits 15:8 on `rd_data[15:8]`. A lane that is not driven reads as zero.
- R6: With both selects active, `wr_n`=1 and `rd_n`=1, the access is output-disable. All lane flags are low and `rd_data` is zero.
- R7: In byte view (`word_mode`=0, both enables low), the byte address is {`addr`, `wr_data[15]`}. A write stores `wr_data[7:0]` into bits 7:0 of word `addr` when `wr_data[15]`=0, or into bits 15:8 when it is 1. The other half of the word keeps its contents, and `wr_data[14:8]` are ignored.
- R8: A byte-view read places the selected half on `rd_data[7:0]` and raises only `drv_lo`. `drv_mid` and `drv_top` stay low, and `rd_data[15:8]` is zero.
- R9: In byte view with both selects active and either enable high, the access is standby with no storage change and `bad_mode` is 1. In every other access `bad_mode` is 0.
- R10: Each output shows the access sampled at a rising edge from just after that edge until the next one. Reads return the contents left by all earlier edges. While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset for the output registers |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| word_mode | input | 1 | 1 = 16-bit word view, 0 = byte view |
| lo_en_n | input | 1 | Active-low enable for data lines 0-7 |
| hi_en_n | input | 1 | Active-low enable for data lines 8-15 |
| wr_n | input | 1 | Active-low write enable |
| rd_n | input | 1 | Active-low output enable |
| addr | input | AW | Word address |
| wr_data | input | 16 | Host-to-memory data; bit 15 is the low address bit in byte view |
| rd_data | output | 16 | Memory-to-host data, zero on lanes that are not driven |
| drv_lo | output | 1 | Lines 0-7 would be driven |
| drv_mid | output | 1 | Lines 8-14 would be driven |
| drv_top | output | 1 | Line 15 would be driven |
| bad_mode | output | 1 | Byte view requested with a lane enable high |

## Verification
A corrupted storage lane or a misrouted half-select stays hidden until that word is read back. A misdecoded control combination shows at the lane flags on the very next edge. The bench first fills every word with a known pattern. A behavioural model then predicts every output flag and data bit for every sampled access, so a bad write appears at the first later read of the affected word, through either view. Random traffic mixes the two views over the same words, which catches a half-select reversed between the byte and word paths.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_READ  = 2'd1,
      ACT_WRITE = 2'd2,
      ACT_HIZ   = 2'd3
   } act_e;

   typedef struct packed {
      act_e       act;
      logic [1:0] lane_we;
      logic [1:0] lane_rd;
      logic       byte_view;
      logic       half;
      logic       bad;
   } dec_t;
endpackage

// File: rtl/dvs_decode.sv
module dvs_decode
   import dvs_pkg::*;
(
   input  logic sel_n,
   input  logic sel,
   input  logic word_mode,
   input  logic lo_en_n,
   input  logic hi_en_n,
   input  logic wr_n,
   input  logic rd_n,
   input  logic a_lsb,
   output dec_t dec
);
   logic chip_on;
   assign chip_on = !sel_n && sel;

   always_comb begin
      dec           = '0;
      dec.act       = ACT_IDLE;
      dec.byte_view = !word_mode;
      dec.half      = a_lsb;
      if (chip_on) begin
         if (word_mode) begin
            if (!(lo_en_n && hi_en_n)) begin
               if (!wr_n) begin
                  dec.act     = ACT_WRITE;
                  dec.lane_we = {!hi_en_n, !lo_en_n};
               end else if (!rd_n) begin
                  dec.act     = ACT_READ;
                  dec.lane_rd = {!hi_en_n, !lo_en_n};
               end else begin
                  dec.act = ACT_HIZ;
               end
            end
         end else begin
            if (lo_en_n || hi_en_n) begin
               dec.bad = 1'b1;
            end else if (!wr_n) begin
               dec.act     = ACT_WRITE;
               dec.lane_we = a_lsb ? 2'b10 : 2'b01;
            end else if (!rd_n) begin
               dec.act     = ACT_READ;
               dec.lane_rd = a_lsb ? 2'b10 : 2'b01;
            end else begin
               dec.act = ACT_HIZ;
            end
         end
      end
   end
endmodule

// File: rtl/dvs_store.sv
module dvs_store #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic [LANES-1:0] lane_we,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = cells[addr];
   end
endmodule

// File: rtl/dvs_outstage.sv
module dvs_outstage
   import dvs_pkg::*;
#(
   parameter int LANE_W = 8,
   localparam int DW    = 2 * LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  act_e          act,
   input  logic          byte_view,
   input  logic          half,
   input  logic [1:0]    lane_rd,
   input  logic          bad_in,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] rd_data,
   output logic          drv_lo,
   output logic          drv_mid,
   output logic          drv_top,
   output logic          bad_mode
);
   logic [DW-1:0] nxt_data;
   logic          nxt_lo, nxt_mid, nxt_top;

   always_comb begin
      nxt_data = '0;
      nxt_lo   = 1'b0;
      nxt_mid  = 1'b0;
      nxt_top  = 1'b0;
      if (act == ACT_READ) begin
         if (byte_view) begin
            nxt_data[LANE_W-1:0] = half ? rdata[DW-1:LANE_W] : rdata[LANE_W-1:0];
            nxt_lo               = 1'b1;
         end else begin
            if (lane_rd[0]) nxt_data[LANE_W-1:0]  = rdata[LANE_W-1:0];
            if (lane_rd[1]) nxt_data[DW-1:LANE_W] = rdata[DW-1:LANE_W];
            nxt_lo  = lane_rd[0];
            nxt_mid = lane_rd[1];
            nxt_top = lane_rd[1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         drv_lo   <= 1'b0;
         drv_mid  <= 1'b0;
         drv_top  <= 1'b0;
         bad_mode <= 1'b0;
      end else begin
         rd_data  <= nxt_data;
         drv_lo   <= nxt_lo;
         drv_mid  <= nxt_mid;
         drv_top  <= nxt_top;
         bad_mode <= bad_in;
      end
   end
endmodule

// File: rtl/dual_view_sram.sv
module dual_view_sram
   import dvs_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          sel,
   input  logic          word_mode,
   input  logic          lo_en_n,
   input  logic          hi_en_n,
   input  logic          wr_n,
   input  logic          rd_n,
   input  logic [AW-1:0] addr,
   input  logic [15:0]   wr_data,
   output logic [15:0]   rd_data,
   output logic          drv_lo,
   output logic          drv_mid,
   output logic          drv_top,
   output logic          bad_mode
);
   localparam int LANE_W = 8;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dual_view_sram: DEPTH must be a power of two of at least 2");
   end

   dec_t        dec;
   logic [15:0] store_wdata;
   logic [15:0] store_rdata;

   dvs_decode u_decode (
      .sel_n     (sel_n),
      .sel       (sel),
      .word_mode (word_mode),
      .lo_en_n   (lo_en_n),
      .hi_en_n   (hi_en_n),
      .wr_n      (wr_n),
      .rd_n      (rd_n),
      .a_lsb     (wr_data[15]),
      .dec       (dec)
   );

   assign store_wdata = dec.byte_view ? {2{wr_data[LANE_W-1:0]}} : wr_data;

   dvs_store #(.DEPTH(DEPTH), .LANES(2), .LANE_W(LANE_W)) u_store (
      .clk     (clk),
      .lane_we (dec.lane_we),
      .addr    (addr),
      .wdata   (store_wdata),
      .rdata   (store_rdata)
   );

   dvs_outstage #(.LANE_W(LANE_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .act       (dec.act),
      .byte_view (dec.byte_view),
      .half      (dec.half),
      .lane_rd   (dec.lane_rd),
      .bad_in    (dec.bad),
      .rdata     (store_rdata),
      .rd_data   (rd_data),
      .drv_lo    (drv_lo),
      .drv_mid   (drv_mid),
      .drv_top   (drv_top),
      .bad_mode  (bad_mode)
   );

   assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_n) || !$past(sel)) |-> (!drv_lo && !drv_mid && !drv_top && rd_data == 16'h0));

   assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_n) |-> (!drv_lo && !drv_mid && !drv_top));

   assert_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sel_n) && $past(sel) && $past(wr_n) && $past(rd_n))
      |-> (!drv_lo && !drv_mid && !drv_top));

   assert_byte_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(word_mode) |-> (!drv_mid && !drv_top && rd_data[15:8] == 8'h0));

   assert_bad_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bad_mode == (!$past(sel_n) && $past(sel) && !$past(word_mode)
                   && ($past(lo_en_n) || $past(hi_en_n))));

   assert_upper_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drv_mid == drv_top);
endmodule

// File: tb/test_dual_view_sram.sv
module test_dual_view_sram;
   localparam int DEPTH = 256;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          sel_n, sel, word_mode, lo_en_n, hi_en_n, wr_n, rd_n;
   logic [AW-1:0] addr;
   logic [15:0]   wr_data;
   logic [15:0]   rd_data;
   logic          drv_lo, drv_mid, drv_top, bad_mode;

   always #4 clk = ~clk;

   dual_view_sram #(.DEPTH(DEPTH)) i_dual_view_sram (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .word_mode(word_mode),
      .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .wr_n(wr_n), .rd_n(rd_n),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
      .drv_lo(drv_lo), .drv_mid(drv_mid), .drv_top(drv_top), .bad_mode(bad_mode)
   );

   logic [15:0] model [DEPTH];
   int vectors     = 0;
   int miscompares = 0;
   bit done        = 1'b0;

   task automatic apply(input string tag, input logic csn, input logic cs1,
                        input logic mw, input logic lbn, input logic ubn,
                        input logic wen, input logic oen,
                        input logic [AW-1:0] a, input logic [15:0] d);
      logic [15:0] e_dq  = '0;
      logic        e_lo  = 1'b0, e_mid = 1'b0, e_top = 1'b0, e_bad = 1'b0;
      logic        do_wr = 1'b0;
      logic [15:0] nw    = model[a];
      sel_n = csn; sel = cs1; word_mode = mw; lo_en_n = lbn; hi_en_n = ubn;
      wr_n = wen; rd_n = oen; addr = a; wr_data = d;
      if (!csn && cs1) begin
         if (mw) begin
            if (!(lbn && ubn)) begin
               if (!wen) begin
                  do_wr = 1'b1;
                  if (!lbn) nw[7:0]  = d[7:0];
                  if (!ubn) nw[15:8] = d[15:8];
               end else if (!oen) begin
                  if (!lbn) begin e_dq[7:0] = model[a][7:0]; e_lo = 1'b1; end
                  if (!ubn) begin e_dq[15:8] = model[a][15:8]; e_mid = 1'b1; e_top = 1'b1; end
               end
            end
         end else if (lbn || ubn) begin
            e_bad = 1'b1;
         end else if (!wen) begin
            do_wr = 1'b1;
            if (d[15]) nw[15:8] = d[7:0];
            else       nw[7:0]  = d[7:0];
         end else if (!oen) begin
            e_dq[7:0] = d[15] ? model[a][15:8] : model[a][7:0];
            e_lo = 1'b1;
         end
      end
      @(posedge clk);
      #1;
      if (do_wr) model[a] = nw;
      vectors++;
      if (rd_data !== e_dq || drv_lo !== e_lo || drv_mid !== e_mid ||
          drv_top !== e_top || bad_mode !== e_bad) begin
         miscompares++;
         $display("FAIL %s: actual dq=%h lo=%b mid=%b top=%b bad=%b expected dq=%h lo=%b mid=%b top=%b bad=%b",
                  tag, rd_data, drv_lo, drv_mid, drv_top, bad_mode,
                  e_dq, e_lo, e_mid, e_top, e_bad);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R10: watchdog expired, actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      sel_n = 1'b0; sel = 1'b1; word_mode = 1'b1; lo_en_n = 1'b0; hi_en_n = 1'b0;
      wr_n = 1'b1; rd_n = 1'b0; addr = '0; wr_data = 16'hFFFF;
      repeat (3) @(posedge clk);
      #1;
      vectors++;
      if (rd_data !== 16'h0 || drv_lo || drv_mid || drv_top || bad_mode) begin
         miscompares++;
         $display("FAIL R10: reset actual dq=%h lo=%b mid=%b top=%b bad=%b expected all zero",
                  rd_data, drv_lo, drv_mid, drv_top, bad_mode);
      end
      rst_n = 1'b1;

      for (int i = 0; i < DEPTH; i++)
         apply("R3 fill", 0, 1, 1, 0, 0, 0, 1, AW'(i), 16'(i * 16'h0101) ^ 16'hA55A);
      apply("R5 word read", 0, 1, 1, 0, 0, 1, 0, 8'd5, 16'h0);
      apply("R5 lower only", 0, 1, 1, 0, 1, 1, 0, 8'd6, 16'h0);
      apply("R5 upper only", 0, 1, 1, 1, 0, 1, 0, 8'd7, 16'h0);
      apply("R3 lower write", 0, 1, 1, 0, 1, 0, 1, 8'd9, 16'h1234);
      apply("R3 readback", 0, 1, 1, 0, 0, 1, 0, 8'd9, 16'h0);
      apply("R3 upper write", 0, 1, 1, 1, 0, 0, 1, 8'd9, 16'hBEEF);
      apply("R3 readback", 0, 1, 1, 0, 0, 1, 0, 8'd9, 16'h0);
      apply("R4 write with rd_n low", 0, 1, 1, 0, 0, 0, 0, 8'd10, 16'hC0DE);
      apply("R4 readback", 0, 1, 1, 0, 0, 1, 0, 8'd10, 16'h0);
      apply("R1 sel_n high write", 1, 1, 1, 0, 0, 0, 0, 8'd11, 16'hDEAD);
      apply("R1 sel low write", 0, 0, 1, 0, 0, 0, 0, 8'd11, 16'hDEAD);
      apply("R1 sel_n high read", 1, 1, 1, 0, 0, 1, 0, 8'd11, 16'h0);
      apply("R1 readback", 0, 1, 1, 0, 0, 1, 0, 8'd11, 16'h0);
      apply("R2 both enables high write", 0, 1, 1, 1, 1, 0, 1, 8'd12, 16'hF00D);
      apply("R2 both enables high read", 0, 1, 1, 1, 1, 1, 0, 8'd12, 16'h0);
      apply("R2 readback", 0, 1, 1, 0, 0, 1, 0, 8'd12, 16'h0);
      apply("R6 output disable", 0, 1, 1, 0, 0, 1, 1, 8'd12, 16'h0);
      apply("R7 byte write low half", 0, 1, 0, 0, 0, 0, 1, 8'd20, 16'h7F11);
      apply("R7 byte write high half", 0, 1, 0, 0, 0, 0, 1, 8'd20, 16'h8022);
      apply("R7 word readback", 0, 1, 1, 0, 0, 1, 0, 8'd20, 16'h0);
      apply("R8 byte read low", 0, 1, 0, 0, 0, 1, 0, 8'd21, 16'h7F00);
      apply("R8 byte read high", 0, 1, 0, 0, 0, 1, 0, 8'd21, 16'h8000);
      apply("R6 byte output disable", 0, 1, 0, 0, 0, 1, 1, 8'd21, 16'h8000);
      apply("R9 byte with lo high write", 0, 1, 0, 1, 0, 0, 1, 8'd22, 16'h0055);
      apply("R9 byte with hi high read", 0, 1, 0, 0, 1, 1, 0, 8'd22, 16'h0);
      apply("R9 readback", 0, 1, 1, 0, 0, 1, 0, 8'd22, 16'h0);
      apply("R9 deselected byte no flag", 1, 1, 0, 1, 1, 1, 0, 8'd22, 16'h0);

      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r = $urandom;
         apply("R10 mixed traffic", r[2:0] == 3'd0, r[5:3] != 3'd0, r[7:6] != 2'd0,
               r[10:8] == 3'd0, r[13:11] == 3'd1, r[14], r[15],
               AW'($urandom), 16'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule